// File: doc/BRIEF.md
# Host Bus Memory Strobe Decoder

This block sits beside a 16-bit host processor bus with a 23-bit word address (byte address bits 23 down to 1). It turns the bus control lines into five registered, active-low memory strobes:
- a read strobe for the program/ROM region;
- a chip select for work RAM;
- an output enable for work RAM;
- a write strobe for the upper byte lane;
- a write strobe for the lower byte lane.

A flag from the system tells the block when a DMA engine owns the bus. While that flag is high, the read and RAM address windows widen, so the engine can reach memory the processor would normally not decode.

Pseudo-static work RAM needs a refresh now and then. A free-running interval counter marks a refresh as due. The next RAM cycle that begins after that point is tagged. When address strobe releases, the tagged cycle keeps its chip select low for two more clocks. In the second of those clocks an extra output-enable pulse is inserted.

The peripheral area (byte addresses 0xC00000 to 0xDFFFFF) falls inside the ROM read window. The ROM read strobe therefore cannot serve alone as a select for that area. Downstream decode must exclude it.

Top module: `hbus_strobe_gen`

## Requirements
- R1: One clock after an edge that samples as_n=0, rd_wr=0 and uds_n=0, wr_hi_n is low; otherwise it is high. wr_lo_n follows the same rule using lds_n.
- R2: With dma_act=0, rom_rd_n is low one clock after an edge that samples as_n=0, rd_wr=1 and adr[23:21] other than 3'b111 (byte addresses 0x000000–0xDFFFFF, the peripheral area included); otherwise it is high.
- R3: With dma_act=1, rom_rd_n is low one clock after any read sampled with as_n=0, whatever the address.
- R4: Outside a refresh extension, ram_cs_n is low one clock after an edge that samples as_n=0 with adr[23:21]=3'b111 when dma_act=0, or with adr[23]=1 when dma_act=1. This holds for reads and writes alike.
- R5: Outside a refresh extension, ram_oe_n is low one clock after an edge that samples as_n=0 and rd_wr=1, with adr[23:21]=3'b111 when dma_act=0 or any address when dma_act=1.
- R6: A counter clears on reset or when a refresh is taken. It then counts clocks up to REFRESH_INTERVAL (default 128) and stays there. A RAM cycle is tagged for refresh only if the counter has reached REFRESH_INTERVAL on the edge where that cycle's RAM select decode first goes true. A cycle that begins earlier ends without extension.
- R7: At the first edge after a tagged cycle where the RAM select decode is false, ram_cs_n stays low for two more clocks. ram_oe_n is high in the first of those clocks and low in the second. Afterwards both follow R4 and R5 again.
- R8: Every strobe is a register output. rom_rd_n, wr_hi_n and wr_lo_n are high one clock after any edge that samples as_n=1. ram_cs_n and ram_oe_n are also high then, unless R7 holds them low.
- R9: Reset (rst=1, sampled synchronously) drives all five strobes high and clears the refresh counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| adr | input | 23 | Word address, byte address bits 23..1 |
| dma_act | input | 1 | High while the DMA engine owns the bus |
| rom_rd_n | output | 1 | ROM/read region strobe, active low |
| ram_cs_n | output | 1 | Work RAM chip select, active low |
| ram_oe_n | output | 1 | Work RAM output enable, active low |
| wr_hi_n | output | 1 | Upper byte lane write strobe, active low |
| wr_lo_n | output | 1 | Lower byte lane write strobe, active low |

## Verification
Random bus cycles of varying length use addresses clustered on the window edges: 0x7FFFFE/0x800000, 0xBFFFFE/0xC00000 and 0xDFFFFE/0xE00000. Direction, byte lanes and the DMA flag are drawn at random for each cycle. This shows whether each window boundary and its DMA widening sits on the right address bit, and whether each lane strobe follows its own data strobe. Directed sequences set apart a RAM cycle that starts before the refresh interval has elapsed (no extension) from one that starts after it. For the second case they check the exact two-clock chip-select extension, with its gap clock followed by the output-enable pulse.

// File: rtl/hbus_strobe_pkg.sv
package hbus_strobe_pkg;

  // Active-high strobe requests produced by the address decoder
  typedef struct packed {
    logic rom;
    logic ram_cs;
    logic ram_oe;
    logic wr_hi;
    logic wr_lo;
  } strobe_req_t;

  // Top three byte-address bits selecting the RAM region (0xE00000 and up)
  localparam logic [2:0] RAM_TOP_CODE = 3'b111;

endpackage

// File: rtl/hbus_window_dec.sv
module hbus_window_dec
  import hbus_strobe_pkg::*;
#(
  parameter int ADR_MSB = 23
) (
  input  logic             as_n,
  input  logic             uds_n,
  input  logic             lds_n,
  input  logic             rd_wr,
  input  logic [ADR_MSB:1] adr,
  input  logic             dma_act,
  output strobe_req_t      req
);

  localparam int TOP_LSB = ADR_MSB - 2;

  logic [2:0] top_bits;
  logic       in_ram_area;
  logic       in_dma_ram_area;
  logic       cyc_act;
  logic       rd_cyc;
  logic       wr_cyc;

  assign top_bits        = adr[ADR_MSB:TOP_LSB];
  assign in_ram_area     = (top_bits == RAM_TOP_CODE);
  assign in_dma_ram_area = adr[ADR_MSB];
  assign cyc_act         = !as_n;
  assign rd_cyc          = cyc_act && rd_wr;
  assign wr_cyc          = cyc_act && !rd_wr;

  always_comb begin
    req        = '0;
    req.wr_hi  = wr_cyc && !uds_n;
    req.wr_lo  = wr_cyc && !lds_n;
    if (dma_act) begin
      req.rom    = rd_cyc;
      req.ram_cs = cyc_act && in_dma_ram_area;
      req.ram_oe = rd_cyc;
    end else begin
      req.rom    = rd_cyc && !in_ram_area;
      req.ram_cs = cyc_act && in_ram_area;
      req.ram_oe = rd_cyc && in_ram_area;
    end
  end

endmodule

// File: rtl/hbus_refresh_seq.sv
module hbus_refresh_seq #(
  parameter int REFRESH_INTERVAL = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic ram_sel,
  output logic hold,
  output logic pulse
);

  localparam int CNT_W = $clog2(REFRESH_INTERVAL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REFRESH_INTERVAL);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             tag_q;
  logic             ph2_q;
  logic             due;
  logic             cyc_begin;
  logic             ext_start;

  assign due       = (cnt_q == CNT_MAX);
  assign cyc_begin = ram_sel && !sel_q && !ph2_q && !tag_q;
  assign ext_start = tag_q && !ram_sel;
  assign hold      = ext_start || ph2_q;
  assign pulse     = ph2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      tag_q <= 1'b0;
      ph2_q <= 1'b0;
    end else begin
      sel_q <= ram_sel;
      ph2_q <= ext_start;
      if (cyc_begin && due) begin
        tag_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        if (ext_start) tag_q <= 1'b0;
        if (!due) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_MAX); // R6

  AST_TAG_ONLY_WHEN_DUE: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_q) |-> $past(due)); // R6

  AST_PULSE_FOLLOWS_START: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(tag_q) && !tag_q); // R7

endmodule

// File: rtl/hbus_strobe_gen.sv
module hbus_strobe_gen
  import hbus_strobe_pkg::*;
#(
  parameter int ADR_MSB          = 23,
  parameter int REFRESH_INTERVAL = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             as_n,
  input  logic             uds_n,
  input  logic             lds_n,
  input  logic             rd_wr,
  input  logic [ADR_MSB:1] adr,
  input  logic             dma_act,
  output logic             rom_rd_n,
  output logic             ram_cs_n,
  output logic             ram_oe_n,
  output logic             wr_hi_n,
  output logic             wr_lo_n
);

  localparam int TOP_LSB = ADR_MSB - 2;

  strobe_req_t req;
  logic        ref_hold;
  logic        ref_pulse;

  hbus_window_dec #(
    .ADR_MSB (ADR_MSB)
  ) u_dec (
    .as_n    (as_n),
    .uds_n   (uds_n),
    .lds_n   (lds_n),
    .rd_wr   (rd_wr),
    .adr     (adr),
    .dma_act (dma_act),
    .req     (req)
  );

  hbus_refresh_seq #(
    .REFRESH_INTERVAL (REFRESH_INTERVAL)
  ) u_ref (
    .clk     (clk),
    .rst     (rst),
    .ram_sel (req.ram_cs),
    .hold    (ref_hold),
    .pulse   (ref_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd_n <= 1'b1;
      ram_cs_n <= 1'b1;
      ram_oe_n <= 1'b1;
      wr_hi_n  <= 1'b1;
      wr_lo_n  <= 1'b1;
    end else begin
      rom_rd_n <= !req.rom;
      wr_hi_n  <= !req.wr_hi;
      wr_lo_n  <= !req.wr_lo;
      ram_cs_n <= !(req.ram_cs || ref_hold);
      ram_oe_n <= ref_hold ? !ref_pulse : !req.ram_oe;
    end
  end

  AST_WR_HI_LANE: assert property (@(posedge clk) disable iff (rst)
    !wr_hi_n |-> $past(!as_n && !uds_n && !rd_wr)); // R1

  AST_WR_LO_LANE: assert property (@(posedge clk) disable iff (rst)
    !wr_lo_n |-> $past(!as_n && !lds_n && !rd_wr)); // R1

  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !rom_rd_n |-> $past(!as_n && rd_wr &&
                        (dma_act || adr[ADR_MSB:TOP_LSB] != RAM_TOP_CODE))); // R2

  AST_ROM_HIGH_AREA_DMA: assert property (@(posedge clk) disable iff (rst)
    !rom_rd_n && $past(adr[ADR_MSB:TOP_LSB] == RAM_TOP_CODE) |-> $past(dma_act)); // R3

  AST_OE_INSIDE_CS: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n && !$past(dma_act) |-> !ram_cs_n); // R5

  AST_PULSE_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
    !ram_oe_n && $past(as_n) |-> $past(!ram_cs_n && ram_oe_n)); // R7

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(as_n) |-> rom_rd_n && wr_hi_n && wr_lo_n); // R8

endmodule

// File: tb/hbus_strobe_gen_tb.sv
module hbus_strobe_gen_tb;

  localparam int INTERVAL = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd_wr = 1'b1, dma_act = 1'b0;
  logic [23:1] adr = '0;
  logic        rom_rd_n, ram_cs_n, ram_oe_n, wr_hi_n, wr_lo_n;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  int m_cnt = 0;
  bit m_tag = 0, m_ph2 = 0, m_selq = 0, m_ref = 0;
  bit e_rom = 1, e_cs = 1, e_oe = 1, e_hi = 1, e_lo = 1;

  always #2 clk = ~clk;

  hbus_strobe_gen #(.REFRESH_INTERVAL(INTERVAL)) u_dut (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rd_wr(rd_wr), .adr(adr), .dma_act(dma_act),
    .rom_rd_n(rom_rd_n), .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n),
    .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n)
  );

  function automatic bit ram_win(logic [23:1] a, logic d);
    return d ? a[23] : (a[23:21] == 3'b111);
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // expected outputs after the edge that samples the current inputs
  task automatic model_edge();
    bit rsel, oes, due, beg;
    if (rst) begin
      {e_rom, e_cs, e_oe, e_hi, e_lo} = 5'b11111;
      m_cnt = 0; m_tag = 0; m_ph2 = 0; m_selq = 0; m_ref = 0;
      return;
    end
    rsel  = !as_n && ram_win(adr, dma_act);
    oes   = !as_n && rd_wr && (dma_act || adr[23:21] == 3'b111);
    e_rom = !(!as_n && rd_wr && (dma_act || adr[23:21] != 3'b111));
    e_hi  = !(!as_n && !rd_wr && !uds_n);
    e_lo  = !(!as_n && !rd_wr && !lds_n);
    due   = (m_cnt == INTERVAL);
    beg   = rsel && !m_selq && !m_ph2 && !m_tag;
    if (m_ph2) begin
      e_cs = 0; e_oe = 0; m_ph2 = 0; m_ref = 1;
    end else if (m_tag && !rsel) begin
      e_cs = 0; e_oe = 1; m_ph2 = 1; m_tag = 0; m_ref = 1;
    end else begin
      e_cs = !rsel; e_oe = !oes; m_ref = 0;
    end
    if (beg && due) begin
      m_tag = 1; m_cnt = 0;
    end else if (!due) begin
      m_cnt++;
    end
    m_selq = rsel;
  endtask

  task automatic cyc(bit a_n, bit u_n, bit l_n, bit rw, logic [23:0] byte_adr, bit d);
    @(negedge clk);
    as_n = a_n; uds_n = u_n; lds_n = l_n; rd_wr = rw; adr = byte_adr[23:1]; dma_act = d;
    @(posedge clk);
    model_edge();
    #1;
    if (rst) begin
      chk("R9 rom_rd_n", rom_rd_n, 1'b1);
      chk("R9 ram_cs_n", ram_cs_n, 1'b1);
      chk("R9 ram_oe_n", ram_oe_n, 1'b1);
      chk("R9 wr_hi_n", wr_hi_n, 1'b1);
      chk("R9 wr_lo_n", wr_lo_n, 1'b1);
    end else begin
      chk("R1 wr_hi_n", wr_hi_n, e_hi);
      chk("R1 wr_lo_n", wr_lo_n, e_lo);
      chk(d ? "R3 rom_rd_n" : "R2 rom_rd_n", rom_rd_n, e_rom);
      chk(m_ref ? "R7 ram_cs_n" : "R4 ram_cs_n", ram_cs_n, e_cs);
      chk(m_ref ? "R7 ram_oe_n" : "R5 ram_oe_n", ram_oe_n, e_oe);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1, 24'h000000, 0);
  endtask

  function automatic logic [23:0] pick_adr();
    logic [23:0] edges [8] = '{24'h7FFFFE, 24'h800000, 24'hBFFFFE, 24'hC00000,
                               24'hDFFFFE, 24'hE00000, 24'hFFFFFE, 24'h000000};
    if ($urandom_range(0, 3) == 0) return {$urandom_range(0, 24'hFFFFFF)} & 24'hFFFFFE;
    return edges[$urandom_range(0, 7)];
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R9: reset holds strobes high even with an active RAM read on the bus
    rst = 1;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 24'hE00000, 0);
    rst = 0;

    // R6: RAM cycle beginning right after reset is not extended
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 24'hE00000, 0);
    cyc(1, 1, 1, 1, 24'hE00000, 0);
    chk("R6 early cycle not extended", ram_cs_n, 1'b1);
    // R8: ROM read ends one clock after strobe release
    cyc(0, 0, 0, 1, 24'h100000, 0);
    cyc(1, 1, 1, 1, 24'h100000, 0);
    chk("R8 rom release", rom_rd_n, 1'b1);

    // R7: wait out the interval, then a RAM write gets the extension
    idle(INTERVAL + 8);
    cyc(0, 0, 1, 0, 24'hFF0000, 0);
    cyc(0, 0, 1, 0, 24'hFF0000, 0);
    cyc(1, 1, 1, 1, 24'hFF0000, 0);
    chk("R7 ext1 cs", ram_cs_n, 1'b0);
    chk("R7 ext1 oe gap", ram_oe_n, 1'b1);
    cyc(1, 1, 1, 1, 24'hFF0000, 0);
    chk("R7 ext2 cs", ram_cs_n, 1'b0);
    chk("R7 ext2 oe pulse", ram_oe_n, 1'b0);
    cyc(1, 1, 1, 1, 24'hFF0000, 0);
    chk("R7 ext end cs", ram_cs_n, 1'b1);
    chk("R7 ext end oe", ram_oe_n, 1'b1);

    // R3/R4: DMA widens windows; peripheral area read hits ROM strobe (R2)
    cyc(0, 0, 0, 1, 24'h800000, 1);
    chk("R3 dma rom", rom_rd_n, 1'b0);
    chk("R4 dma ram cs", ram_cs_n, 1'b0);
    cyc(0, 0, 0, 1, 24'hC00000, 0);
    chk("R2 peripheral overlap", rom_rd_n, 1'b0);
    chk("R4 no cs below ram", ram_cs_n, 1'b1);
    idle(2);

    // random bus cycles
    for (int n = 0; n < 3000; n++) begin
      logic [23:0] a = pick_adr();
      bit rw = $urandom_range(0, 1);
      bit d  = ($urandom_range(0, 3) == 0);
      bit u  = $urandom_range(0, 1);
      bit l  = (u == 1) ? 1'b0 : 1'($urandom_range(0, 1));
      int len = $urandom_range(1, 5);
      for (int k = 0; k < len; k++) cyc(0, u, l, rw, a, d);
      for (int k = 0; k < int'($urandom_range(1, 2)); k++)
        cyc(1, 1, 1, 1'($urandom_range(0, 1)), pick_adr(), 1'($urandom_range(0, 1)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule